// File: doc/BRIEF.md
# Control Register Write Hazard Unit

This unit guards a five-stage in-order pipeline (Decode, Address, Memory, Execute, Writeback) against instructions that write a protected core control register. It keeps a small shadow copy of the writers that have left Decode. While writers are in flight it does one of two things. It either holds selected instruction classes in Decode, or it cancels the pipeline and the prefetch buffer when a writer to a CPU-wide register reaches Execute.

Protected registers carry a numeric identifier. Identifiers below `CPU_N` form the CPU-wide group: control word, context base, stack pointer, both stack limits, vector base, trap flags and status word. All higher identifiers form the address-path group: index, offset and page registers. A writer in the address-path group never cancels anything; it only delays the instructions that would read the address path. A writer that uses pop-to-register or register-with-16-bit-immediate takes the fast path, which holds only the sensitive classes. A writer using any other mode holds every later instruction. A cancel is followed one cycle later by a restart request, which carries the address of the instruction after the writer.

The unit assumes that the stages behind Decode advance every cycle. The only bubbles are those that its own hold inserts.

Top module: `csr_wr_hazard`

## Requirements
- R1: While reset is asserted, and in the first cycle after reset is released, `dec_hold`, `flush_pipe`, `flush_pref` and `restart_req` are low. Reset discards every writer that is in flight.
- R2: While a fast-path writer (mode 1 = pop, mode 2 = register-immediate) is in flight, a valid Decode instruction is held if its class is one of the following: 1 (long/direct memory), 2 (indirect data access), 4 (watchdog on/off or end-of-init) or 5 (coprocessor/MAC).
- R3: Classes 0 (plain), 3 (indirect jump/call) and 6–7 are never held by a fast-path writer. A writer in Decode is not held by its own write.
- R4: A writer accepted in Decode in cycle t is in Execute in cycle t+3. The hold it causes ends in cycle t+4.
- R5: When a writer to a CPU-wide register (identifier below 8) is in Execute, `flush_pipe` and `flush_pref` are both high in that cycle, whatever its mode.
- R6: In the cycle after a flush, `restart_req` is high for exactly one cycle. In that cycle `restart_pc` equals the next-instruction address that was given with the writer in Decode.
- R7: A writer to an address-path register (identifier 8–15) never raises `flush_pipe`.
- R8: A writer with mode 0 or 3 holds every valid Decode instruction, of any class, until it leaves Execute.
- R9: In a flush cycle `dec_hold` is low. The flush discards all younger writers, so in later cycles they cause neither a hold nor a flush.
- R10: Writers that follow one another back to back are accepted without a stall. A held class stays held until the last of them has left Execute.
- R11: `dec_hold` is never high when `dec_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dec_vld | input | 1 | Decode holds a valid instruction |
| dec_cls | input | 3 | Decoded instruction class (encoding in R2/R3) |
| dec_wr | input | 1 | Instruction writes a protected register |
| dec_dst | input | RID_W | Protected register identifier |
| dec_mode | input | 2 | Writing mode: 1 pop, 2 register-immediate, 0/3 other |
| dec_nxt_pc | input | AW | Address of the instruction following the one in Decode |
| dec_hold | output | 1 | Keep the Decode instruction and insert a bubble |
| flush_pipe | output | 1 | Cancel all stages younger than Execute |
| flush_pref | output | 1 | Cancel the prefetch buffer |
| restart_req | output | 1 | Restart fetch |
| restart_pc | output | AW | Fetch restart address |

## Verification
`dec_hold` and both flush outputs are combinational functions of the Decode inputs and of state registered at the previous edge. The bench therefore drives each stimulus row just after a falling edge and reads these outputs 1 ns later, in the same cycle. Relative to a writer accepted in cycle t, the flush is expected in t+3, the restart request and address in t+4, and the hold release in t+4. Each table row states its expected values for its own cycle with this offset already applied. The held instruction is presented again on every row until its release row.

// File: rtl/hcu_pkg.sv
`timescale 1ns/1ps
package hcu_pkg;

   typedef enum logic [2:0] {
      CLS_PLAIN   = 3'd0,
      CLS_LONGMEM = 3'd1,
      CLS_INDIR   = 3'd2,
      CLS_INDBR   = 3'd3,
      CLS_SYSINIT = 3'd4,
      CLS_COPROC  = 3'd5,
      CLS_RSV6    = 3'd6,
      CLS_RSV7    = 3'd7
   } icls_e;

   typedef enum logic [1:0] {
      WM_OTHER0 = 2'd0,
      WM_POP    = 2'd1,
      WM_IMM    = 2'd2,
      WM_OTHER3 = 2'd3
   } wmode_e;

   // classes that read the address path and must wait for a fast-path writer
   function automatic logic cls_sensitive(input icls_e c);
      case (c)
         CLS_LONGMEM, CLS_INDIR, CLS_SYSINIT, CLS_COPROC: return 1'b1;
         default:                                         return 1'b0;
      endcase
   endfunction

   function automatic logic mode_fast(input wmode_e m);
      return (m == WM_POP) || (m == WM_IMM);
   endfunction

endpackage

// File: rtl/hcu_decode.sv
`timescale 1ns/1ps
module hcu_decode #(
   parameter int RID_W = 4,
   parameter int CPU_N = 8
) (
   input  logic [2:0]       cls,
   input  logic [1:0]       mode,
   input  logic [RID_W-1:0] dst,
   output logic             sens,
   output logic             fast,
   output logic             cpu
);
   import hcu_pkg::*;

   localparam logic [RID_W:0] CPU_LIM = (RID_W+1)'(CPU_N);

   always_comb begin
      sens = cls_sensitive(icls_e'(cls));
      fast = mode_fast(wmode_e'(mode));
      cpu  = ({1'b0, dst} < CPU_LIM);
   end

endmodule

// File: rtl/hcu_track.sv
`timescale 1ns/1ps
module hcu_track #(
   parameter int AW   = 16,
   parameter int NSTG = 3,
   parameter int CW   = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic          push_cpu,
   input  logic          push_fast,
   input  logic [AW-1:0] push_pc,
   output logic          ex_cpu,
   output logic [AW-1:0] ex_pc,
   output logic [CW-1:0] fcnt,
   output logic [CW-1:0] scnt
);

   localparam int LAST = NSTG - 1;

   logic          s_vld  [NSTG];
   logic          s_cpu  [NSTG];
   logic          s_fast [NSTG];
   logic [AW-1:0] s_pc   [NSTG];

   logic ret_fast, ret_slow;
   logic inc_fast, inc_slow;

   always_comb begin
      ret_fast = s_vld[LAST] &&  s_fast[LAST];
      ret_slow = s_vld[LAST] && !s_fast[LAST];
      inc_fast = push &&  push_fast;
      inc_slow = push && !push_fast;
      ex_cpu   = s_vld[LAST] && s_cpu[LAST];
      ex_pc    = s_pc[LAST];
   end

   // shadow of the writers between Decode and the end of Execute
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NSTG; i++) begin
            s_vld[i]  <= 1'b0;
            s_cpu[i]  <= 1'b0;
            s_fast[i] <= 1'b0;
            s_pc[i]   <= '0;
         end
      end else if (flush) begin
         for (int i = 0; i < NSTG; i++) begin
            s_vld[i] <= 1'b0;
         end
      end else begin
         for (int i = NSTG - 1; i > 0; i--) begin
            s_vld[i]  <= s_vld[i-1];
            s_cpu[i]  <= s_cpu[i-1];
            s_fast[i] <= s_fast[i-1];
            s_pc[i]   <= s_pc[i-1];
         end
         s_vld[0]  <= push;
         s_cpu[0]  <= push_cpu;
         s_fast[0] <= push_fast;
         s_pc[0]   <= push_pc;
      end
   end

   // pending-writer counters, one per hold policy
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fcnt <= '0;
         scnt <= '0;
      end else if (flush) begin
         fcnt <= '0;
         scnt <= '0;
      end else begin
         fcnt <= fcnt + CW'(inc_fast) - CW'(ret_fast);
         scnt <= scnt + CW'(inc_slow) - CW'(ret_slow);
      end
   end

endmodule

// File: rtl/hcu_restart.sv
`timescale 1ns/1ps
module hcu_restart #(
   parameter int AW          = 16,
   parameter bit RESTART_REG = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic [AW-1:0] flush_pc,
   output logic          req,
   output logic [AW-1:0] pc
);

   if (RESTART_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            req <= 1'b0;
            pc  <= '0;
         end else begin
            req <= flush;
            if (flush) pc <= flush_pc;
         end
      end
   end else begin : g_comb
      logic unused_ck;
      assign unused_ck = clk ^ rst_n;
      assign req = flush;
      assign pc  = flush_pc;
   end

endmodule

// File: rtl/csr_wr_hazard.sv
`timescale 1ns/1ps
module csr_wr_hazard #(
   parameter int AW          = 16,
   parameter int RID_W       = 4,
   parameter int CPU_N       = 8,
   parameter int NSTG        = 3,
   parameter bit RESTART_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dec_vld,
   input  logic [2:0]       dec_cls,
   input  logic             dec_wr,
   input  logic [RID_W-1:0] dec_dst,
   input  logic [1:0]       dec_mode,
   input  logic [AW-1:0]    dec_nxt_pc,
   output logic             dec_hold,
   output logic             flush_pipe,
   output logic             flush_pref,
   output logic             restart_req,
   output logic [AW-1:0]    restart_pc
);

   localparam int CW = $clog2(NSTG + 1);

   if (NSTG < 1) begin : g_bad_nstg
      $error("NSTG must be at least 1");
   end
   if (CPU_N < 1 || CPU_N >= (1 << RID_W)) begin : g_bad_cpun
      $error("CPU_N must leave both register groups non-empty");
   end
   if (AW < 1) begin : g_bad_aw
      $error("AW must be positive");
   end

   logic          sens, fast, cpu;
   logic          flush, ex_cpu, push;
   logic [AW-1:0] ex_pc;
   logic [CW-1:0] fcnt, scnt;

   hcu_decode #(.RID_W(RID_W), .CPU_N(CPU_N)) u_dec (
      .cls (dec_cls),
      .mode(dec_mode),
      .dst (dec_dst),
      .sens(sens),
      .fast(fast),
      .cpu (cpu)
   );

   always_comb begin
      flush    = ex_cpu;
      dec_hold = dec_vld && !flush &&
                 ((fcnt != '0 && sens) || scnt != '0);
      push     = dec_vld && dec_wr && !dec_hold && !flush;
   end

   hcu_track #(.AW(AW), .NSTG(NSTG), .CW(CW)) u_trk (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (flush),
      .push     (push),
      .push_cpu (cpu),
      .push_fast(fast),
      .push_pc  (dec_nxt_pc),
      .ex_cpu   (ex_cpu),
      .ex_pc    (ex_pc),
      .fcnt     (fcnt),
      .scnt     (scnt)
   );

   hcu_restart #(.AW(AW), .RESTART_REG(RESTART_REG)) u_rst (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (flush),
      .flush_pc(ex_pc),
      .req     (restart_req),
      .pc      (restart_pc)
   );

   assign flush_pipe = flush;
   assign flush_pref = flush;

endmodule

// File: rtl/csr_wr_hazard_chk.sv
`timescale 1ns/1ps
module csr_wr_hazard_chk #(
   parameter int NSTG        = 3,
   parameter int CW          = 2,
   parameter bit RESTART_REG = 1'b1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          dec_vld,
   input logic          dec_hold,
   input logic          flush_pipe,
   input logic          flush_pref,
   input logic          restart_req,
   input logic [CW-1:0] fcnt,
   input logic [CW-1:0] scnt
);

   a_r5_flush_pair: assert property (@(posedge clk) disable iff (!rst_n)
      flush_pipe |-> flush_pref)
      else $error("R5 prefetch flush missing");

   a_r5_pref_pair: assert property (@(posedge clk) disable iff (!rst_n)
      flush_pref |-> flush_pipe)
      else $error("R5 lone prefetch flush");

   a_r9_flush_over_hold: assert property (@(posedge clk) disable iff (!rst_n)
      flush_pipe |-> !dec_hold)
      else $error("R9 hold during flush");

   a_r9_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
      flush_pipe |=> (fcnt == '0 && scnt == '0))
      else $error("R9 tracking kept after flush");

   a_r11_hold_needs_vld: assert property (@(posedge clk) disable iff (!rst_n)
      dec_hold |-> dec_vld)
      else $error("R11 hold without valid");

   a_r10_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, fcnt} + {1'b0, scnt}) <= (CW+1)'(NSTG))
      else $error("R10 more writers than stages");

   a_r3_idle_no_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (fcnt == '0 && scnt == '0) |-> !dec_hold)
      else $error("R3 hold with nothing pending");

   if (RESTART_REG) begin : g_rr
      a_r6_restart_follows: assert property (@(posedge clk) disable iff (!rst_n)
         flush_pipe |=> restart_req)
         else $error("R6 restart missing");

      a_r6_restart_only_after: assert property (@(posedge clk) disable iff (!rst_n)
         restart_req |-> $past(flush_pipe))
         else $error("R6 spurious restart");
   end

endmodule

bind csr_wr_hazard csr_wr_hazard_chk #(
   .NSTG(NSTG), .CW(CW), .RESTART_REG(RESTART_REG)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .dec_vld    (dec_vld),
   .dec_hold   (dec_hold),
   .flush_pipe (flush_pipe),
   .flush_pref (flush_pref),
   .restart_req(restart_req),
   .fcnt       (fcnt),
   .scnt       (scnt)
);

// File: tb/tb_csr_wr_hazard.sv
`timescale 1ns/1ps
module tb_csr_wr_hazard;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        dec_vld;
   logic [2:0]  dec_cls;
   logic        dec_wr;
   logic [3:0]  dec_dst;
   logic [1:0]  dec_mode;
   logic [15:0] dec_nxt_pc;
   logic        dec_hold, flush_pipe, flush_pref, restart_req;
   logic [15:0] restart_pc;

   int  n_chk  = 0;
   int  n_fail = 0;
   bit  done   = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   csr_wr_hazard dut (
      .clk(clk), .rst_n(rst_n), .dec_vld(dec_vld), .dec_cls(dec_cls),
      .dec_wr(dec_wr), .dec_dst(dec_dst), .dec_mode(dec_mode),
      .dec_nxt_pc(dec_nxt_pc), .dec_hold(dec_hold), .flush_pipe(flush_pipe),
      .flush_pref(flush_pref), .restart_req(restart_req), .restart_pc(restart_pc)
   );

   typedef struct packed {
      logic        vld;
      logic [2:0]  cls;
      logic        wr;
      logic [3:0]  dst;
      logic [1:0]  mode;
      logic [15:0] pc;
      logic        e_hold;
      logic        e_flush;
      logic        e_rr;
      logic [15:0] e_pc;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 43;
   // vld cls wr dst mode pc | hold flush rr pc | req
   localparam vec_t TBL [NV] = '{
      // index write (fast) then indirect load: stall
      '{1'b1,3'd0,1'b1,4'd8, 2'd2,16'h0000, 1'b0,1'b0,1'b0,16'h0000, 4'd3},
      '{1'b0,3'd2,1'b0,4'd0, 2'd0,16'h0000, 1'b0,1'b0,1'b0,16'h0000, 4'd11},
      '{1'b1,3'd2,1'b0,4'd0, 2'd0,16'h0000, 1'b1,1'b0,1'b0,16'h0000, 4'd2},
      '{1'b1,3'd2,1'b0,4'd0, 2'd0,16'h0000, 1'b1,1'b0,1'b0,16'h0000, 4'd2},
      '{1'b1,3'd2,1'b0,4'd0, 2'd0,16'h0000, 1'b0,1'b0,1'b0,16'h0000, 4'd4},
      // index write then register move and indirect branch: no stall
      '{1'b1,3'd0,1'b1,4'd9, 2'd2,16'h0000, 1'b0,1'b0,1'b0,16'h0000, 4'd3},
      '{1'b1,3'd0,1'b0,4'd0, 2'd0,16'h0000, 1'b0,1'b0,1'b0,16'h0000, 4'd3},
      '{1'b1,3'd3,1'b0,4'd0, 2'd0,16'h0000, 1'b0,1'b0,1'b0,16'h0000, 4'd3},
      '{1'b0,3'd0,1'b0,4'd0, 2'd0,16'h0000, 1'b0,1'b0,1'b0,16'h0000, 4'd7},
      '{1'b0,3'd0,1'b0,4'd0, 2'd0,16'h0000, 1'b0,1'b0,1'b0,16'h0000, 4'd7},
      // status word write by pop: flush and restart
      '{1'b1,3'd0,1'b1,4'd7, 2'd1,16'h0040, 1'b0,1'b0,1'b0,16'h0000, 4'd3},
      '{1'b1,3'd0,1'b0,4'd0, 2'd0,16'h0000, 1'b0,1'b0,1'b0,16'h0000, 4'd3},
      '{1'b1,3'd5,1'b0,4'd0, 2'd0,16'h0000, 1'b1,1'b0,1'b0,16'h0000, 4'd2},
      '{1'b1,3'd5,1'b0,4'd0, 2'd0,16'h0000, 1'b0,1'b1,1'b0,16'h0000, 4'd5},
      '{1'b1,3'd5,1'b0,4'd0, 2'd0,16'h0000, 1'b0,1'b0,1'b1,16'h0040, 4'd6},
      '{1'b0,3'd0,1'b0,4'd0, 2'd0,16'h0000, 1'b0,1'b0,1'b0,16'h0000, 4'd6},
      // back-to-back page pointer writes
      '{1'b1,3'd0,1'b1,4'd12,2'd2,16'h0000, 1'b0,1'b0,1'b0,16'h0000, 4'd10},
      '{1'b1,3'd0,1'b1,4'd13,2'd2,16'h0000, 1'b0,1'b0,1'b0,16'h0000, 4'd10},
      '{1'b1,3'd0,1'b1,4'd14,2'd2,16'h0000, 1'b0,1'b0,1'b0,16'h0000, 4'd10},
      '{1'b1,3'd1,1'b0,4'd0, 2'd0,16'h0000, 1'b1,1'b0,1'b0,16'h0000, 4'd10},
      '{1'b1,3'd1,1'b0,4'd0, 2'd0,16'h0000, 1'b1,1'b0,1'b0,16'h0000, 4'd10},
      '{1'b1,3'd1,1'b0,4'd0, 2'd0,16'h0000, 1'b1,1'b0,1'b0,16'h0000, 4'd10},
      '{1'b1,3'd1,1'b0,4'd0, 2'd0,16'h0000, 1'b0,1'b0,1'b0,16'h0000, 4'd4},
      '{1'b0,3'd0,1'b0,4'd0, 2'd0,16'h0000, 1'b0,1'b0,1'b0,16'h0000, 4'd7},
      // address-path write in another mode: hold everything
      '{1'b1,3'd0,1'b1,4'd10,2'd0,16'h0000, 1'b0,1'b0,1'b0,16'h0000, 4'd8},
      '{1'b1,3'd0,1'b0,4'd0, 2'd0,16'h0000, 1'b1,1'b0,1'b0,16'h0000, 4'd8},
      '{1'b1,3'd0,1'b0,4'd0, 2'd0,16'h0000, 1'b1,1'b0,1'b0,16'h0000, 4'd8},
      '{1'b1,3'd0,1'b0,4'd0, 2'd0,16'h0000, 1'b1,1'b0,1'b0,16'h0000, 4'd7},
      '{1'b1,3'd0,1'b0,4'd0, 2'd0,16'h0000, 1'b0,1'b0,1'b0,16'h0000, 4'd4},
      '{1'b0,3'd0,1'b0,4'd0, 2'd0,16'h0000, 1'b0,1'b0,1'b0,16'h0000, 4'd7},
      // CPU-wide write in another mode: hold all, then flush
      '{1'b1,3'd0,1'b1,4'd2, 2'd3,16'h0080, 1'b0,1'b0,1'b0,16'h0000, 4'd8},
      '{1'b1,3'd3,1'b0,4'd0, 2'd0,16'h0000, 1'b1,1'b0,1'b0,16'h0000, 4'd8},
      '{1'b1,3'd3,1'b0,4'd0, 2'd0,16'h0000, 1'b1,1'b0,1'b0,16'h0000, 4'd8},
      '{1'b1,3'd3,1'b0,4'd0, 2'd0,16'h0000, 1'b0,1'b1,1'b0,16'h0000, 4'd9},
      '{1'b1,3'd3,1'b0,4'd0, 2'd0,16'h0000, 1'b0,1'b0,1'b1,16'h0080, 4'd6},
      '{1'b0,3'd0,1'b0,4'd0, 2'd0,16'h0000, 1'b0,1'b0,1'b0,16'h0000, 4'd6},
      // flush discards a younger CPU-wide writer
      '{1'b1,3'd0,1'b1,4'd0, 2'd2,16'h0010, 1'b0,1'b0,1'b0,16'h0000, 4'd10},
      '{1'b1,3'd0,1'b1,4'd5, 2'd1,16'h0020, 1'b0,1'b0,1'b0,16'h0000, 4'd10},
      '{1'b1,3'd2,1'b0,4'd0, 2'd0,16'h0000, 1'b1,1'b0,1'b0,16'h0000, 4'd2},
      '{1'b1,3'd2,1'b0,4'd0, 2'd0,16'h0000, 1'b0,1'b1,1'b0,16'h0000, 4'd9},
      '{1'b1,3'd2,1'b0,4'd0, 2'd0,16'h0000, 1'b0,1'b0,1'b1,16'h0010, 4'd9},
      '{1'b0,3'd0,1'b0,4'd0, 2'd0,16'h0000, 1'b0,1'b0,1'b0,16'h0000, 4'd9},
      '{1'b0,3'd0,1'b0,4'd0, 2'd0,16'h0000, 1'b0,1'b0,1'b0,16'h0000, 4'd9}
   };

   function automatic string rname(input int r);
      case (r)
         1:  return "R1";
         2:  return "R2";
         3:  return "R3";
         4:  return "R4";
         5:  return "R5";
         6:  return "R6";
         7:  return "R7";
         8:  return "R8";
         9:  return "R9";
         10: return "R10";
         default: return "R11";
      endcase
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", req, what, act, exp, $time);
      end
   endtask

   task automatic drive(input logic v, input logic [2:0] c, input logic w,
                        input logic [3:0] d, input logic [1:0] m, input logic [15:0] p);
      dec_vld = v; dec_cls = c; dec_wr = w; dec_dst = d; dec_mode = m; dec_nxt_pc = p;
   endtask

   task automatic chk_quiet(input string req);
      chk(req, "hold",  {15'd0, dec_hold},    16'd0);
      chk(req, "flush", {15'd0, flush_pipe},  16'd0);
      chk(req, "pref",  {15'd0, flush_pref},  16'd0);
      chk(req, "rr",    {15'd0, restart_req}, 16'd0);
   endtask

   initial begin
      rst_n = 1'b0;
      drive(1'b1, 3'd2, 1'b0, 4'd0, 2'd0, 16'h0);
      repeat (3) @(posedge clk);
      @(negedge clk); #1;
      chk_quiet("R1");                         // r1_ outputs idle in reset
      rst_n = 1'b1;
      #1;
      chk_quiet("R1");

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         drive(TBL[i].vld, TBL[i].cls, TBL[i].wr, TBL[i].dst, TBL[i].mode, TBL[i].pc);
         #1;
         chk(rname(int'(TBL[i].req)), "hold",  {15'd0, dec_hold},   {15'd0, TBL[i].e_hold});
         chk(rname(int'(TBL[i].req)), "flush", {15'd0, flush_pipe}, {15'd0, TBL[i].e_flush});
         chk(rname(int'(TBL[i].req)), "pref",  {15'd0, flush_pref}, {15'd0, TBL[i].e_flush});
         chk(rname(int'(TBL[i].req)), "rr",    {15'd0, restart_req},{15'd0, TBL[i].e_rr});
         if (TBL[i].e_rr)
            chk(rname(int'(TBL[i].req)), "restart_pc", restart_pc, TBL[i].e_pc);
      end

      // R1: reset discards a pending writer
      @(negedge clk);
      drive(1'b1, 3'd0, 1'b1, 4'd3, 2'd2, 16'h0099);
      @(negedge clk);
      drive(1'b1, 3'd4, 1'b0, 4'd0, 2'd0, 16'h0);
      #1;
      chk("R2", "hold sysinit", {15'd0, dec_hold}, 16'd1);
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R1", "hold in reset", {15'd0, dec_hold}, 16'd0);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk_quiet("R1");
      repeat (4) begin
         @(negedge clk); #1;
         chk("R1", "no flush from discarded writer", {15'd0, flush_pipe}, 16'd0);
         chk("R1", "no hold after reset", {15'd0, dec_hold}, 16'd0);
      end

      // R11: idle Decode under a mode-0 writer is never held
      @(negedge clk);
      drive(1'b1, 3'd0, 1'b1, 4'd15, 2'd0, 16'h0);
      @(negedge clk);
      drive(1'b0, 3'd1, 1'b0, 4'd0, 2'd0, 16'h0);
      #1;
      chk("R11", "hold without valid", {15'd0, dec_hold}, 16'd0);
      drive(1'b1, 3'd6, 1'b0, 4'd0, 2'd0, 16'h0);
      #1;
      chk("R8", "reserved class held by slow writer", {15'd0, dec_hold}, 16'd1);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule